// File: doc/BRIEF.md
# Dithered 14-bit PWM generator

This block turns a 14-bit duty word into a single pulse-width output whose average over a conversion cycle of 16384 resolution ticks equals the duty word exactly. The conversion cycle is divided into equal base cycles. Each base cycle starts with a pulse of fixed width taken from the upper duty bits. A subset of base cycles, chosen from the lower duty bits, is one tick longer. Because those widened cycles are spread evenly across the conversion cycle, the ripple left after filtering stays low.

A configuration bit chooses between 256 base cycles of 64 ticks (short mode) and 64 base cycles of 256 ticks (long mode). A second bit swaps the output polarity. The resolution tick comes from an external enable strobe on the clock. Configuration words enter through a valid/ready port. The block never applies back-pressure: `cfg_ready` is always high, and a word is taken on every clock in which `cfg_valid` is high. If several words arrive before a conversion boundary, the last one wins.

Top module: `pwmd_top`

## Requirements
- R1: After reset the tick counter is zero, the stored configuration is all zero and `pwm_out` is low.
- R2: In long mode (`cfg_long`=1) a base cycle lasts 256 ticks and its pulse is duty bits 13..6 ticks wide, starting at the first tick of the base cycle.
- R3: In short mode (`cfg_long`=0) a base cycle lasts 64 ticks and its pulse is duty bits 13..8 ticks wide, starting at the first tick of the base cycle.
- R4: Base cycle k of a conversion gets one extra tick, appended at the trailing edge of its pulse, when k with its bits reversed is less than the low field. In long mode k is 6 bits wide and the low field is duty bits 5..0. In short mode k is 8 bits wide and the low field is duty bits 7..0.
- R5: Over the 16384 ticks of one conversion cycle, the number of ticks at the active level equals the duty value.
- R6: With `cfg_invert`=1 the output is the complement, so the programmed width becomes low time.
- R7: An accepted configuration word is held in a pending register. It becomes active only at the clock where the counter wraps from 16383 to 0. While the block is disabled, it becomes active at the next clock.
- R8: While `enable` is low the counter is held at zero and `pwm_out` shows the inactive level (the active polarity bit: low, or high when inverted).
- R9: While enabled, the counter advances by one only on clocks with `tick_en` high. On all other clocks the counter and the output are unchanged.
- R10: `cfg_ready` is always high. Each clock with `cfg_valid` high accepts a word, and the last word accepted before activation is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Resolution tick strobe |
| enable | input | 1 | Run enable; low clears the counter and idles the output |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_ready | output | 1 | Configuration accepted (always high) |
| cfg_duty | input | 14 | Duty value |
| cfg_long | input | 1 | 1: 256-tick base cycle, 0: 64-tick base cycle |
| cfg_invert | input | 1 | 1: inverted output polarity |
| pwm_out | output | 1 | PWM output |

## Verification
The bench compares the output on every tick against a reference model built from the requirements. It does this for several duty words:
- a small long-mode value with a few extra ticks, which checks that base width and dither are separated correctly;
- a dense short-mode value, which checks the other field split and the 8-bit reversal;
- the all-ones value, which checks that the widest pulse fills the whole base cycle;
- an inverted value, which checks the polarity swap.

For each of these the active ticks are also counted over a full conversion and compared with the duty word. Further runs cover the following:
- a mid-conversion write, which separates pending storage from immediate use;
- gapped ticks, which show that the counter advances only on the strobe;
- disabling mid-run and back-to-back writes, which check the idle level and that the last write wins.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;
  parameter int DUTY_W   = 14;
  parameter int LONG_BW  = 8;
  parameter int SHORT_BW = 6;

  typedef struct packed {
    logic              long_mode;
    logic              invert;
    logic [DUTY_W-1:0] duty;
  } pwmd_cfg_t;
endpackage

// File: rtl/pwmd_counter.sv
module pwmd_counter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = '1;

  assign wrap = enable && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!enable) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwmd_shadow.sv
module pwmd_shadow
  import pwmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      wr,
  input  pwmd_cfg_t wr_cfg,
  input  logic      wrap,
  output pwmd_cfg_t pend,
  output pwmd_cfg_t act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
    end else begin
      if (wr)              pend <= wr_cfg;
      if (!enable || wrap) act  <= pend;
    end
  end
endmodule

// File: rtl/pwmd_slice.sv
module pwmd_slice #(
  parameter int DW = 14,
  parameter int BW = 8
) (
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] duty,
  output logic          high
);
  localparam int KW = DW - BW;

  logic [BW-1:0] pos;
  logic [BW-1:0] width;
  logic [KW-1:0] k_idx;
  logic [KW-1:0] k_rev;
  logic [KW-1:0] low;
  logic          extra;
  logic [BW:0]   span;

  assign pos   = cnt[BW-1:0];
  assign k_idx = cnt[DW-1:BW];
  assign width = duty[DW-1:KW];
  assign low   = duty[KW-1:0];

  for (genvar i = 0; i < KW; i++) begin : g_rev
    assign k_rev[i] = k_idx[KW-1-i];
  end

  // Spread the extra ticks evenly: a base cycle is widened when its
  // reversed index falls below the low field.
  assign extra = (k_rev < low);
  assign span  = {1'b0, width} + {{BW{1'b0}}, extra};
  assign high  = ({1'b0, pos} < span);
endmodule

// File: rtl/pwmd_top.sv
module pwmd_top
  import pwmd_pkg::*;
#(
  parameter int LBW = LONG_BW,
  parameter int SBW = SHORT_BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              enable,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [DUTY_W-1:0] cfg_duty,
  input  logic              cfg_long,
  input  logic              cfg_invert,
  output logic              pwm_out
);
  localparam int NMODE = 2;

  logic [DUTY_W-1:0] cnt_q;
  logic              wrap;
  logic              wr;
  pwmd_cfg_t         wr_cfg;
  pwmd_cfg_t         pend_cfg;
  pwmd_cfg_t         act_cfg;
  logic [NMODE-1:0]  high_vec;
  logic              high;

  assign cfg_ready = 1'b1;
  assign wr        = cfg_valid && cfg_ready;
  assign wr_cfg    = '{long_mode: cfg_long, invert: cfg_invert, duty: cfg_duty};

  pwmd_counter #(.W(DUTY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick_en),
    .cnt(cnt_q), .wrap(wrap)
  );

  pwmd_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr(wr), .wr_cfg(wr_cfg),
    .wrap(wrap), .pend(pend_cfg), .act(act_cfg)
  );

  // Index 0: short base cycle, index 1: long base cycle.
  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    localparam int BW = (m == 0) ? SBW : LBW;
    pwmd_slice #(.DW(DUTY_W), .BW(BW)) u_slice (
      .cnt(cnt_q), .duty(act_cfg.duty), .high(high_vec[m])
    );
  end

  assign high    = high_vec[act_cfg.long_mode];
  assign pwm_out = enable ? (high ^ act_cfg.invert) : act_cfg.invert;
endmodule

// File: rtl/pwmd_checker.sv
module pwmd_checker
  import pwmd_pkg::*;
#(
  parameter int LBW = LONG_BW,
  parameter int SBW = SHORT_BW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              tick_en,
  input logic [DUTY_W-1:0] cnt,
  input pwmd_cfg_t         act,
  input logic              pwm_out
);
  localparam logic [DUTY_W-1:0] LAST = '1;

  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick_en) |=> $stable(cnt));

  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick_en) |=> (cnt == ($past(cnt) + 1'b1)));

  p_clear_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0));

  p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (pwm_out == act.invert));

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !(tick_en && cnt == LAST)) |=> $stable(act));

  p_lead_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && act.long_mode && cnt[LBW-1:0] == '0 &&
     act.duty[DUTY_W-1 -: LBW] != '0) |-> (pwm_out != act.invert));

  p_lead_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !act.long_mode && cnt[SBW-1:0] == '0 &&
     act.duty[DUTY_W-1 -: SBW] != '0) |-> (pwm_out != act.invert));
endmodule

bind pwmd_top pwmd_checker #(.LBW(LBW), .SBW(SBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tick_en(tick_en),
  .cnt(cnt_q), .act(act_cfg), .pwm_out(pwm_out)
);

// File: tb/pwmd_top_bench.sv
module pwmd_top_bench;
  localparam int CONV = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [13:0] cfg_duty = '0;
  logic        cfg_long = 1'b0;
  logic        cfg_invert = 1'b0;
  logic        pwm_out;

  always #2 clk = ~clk;

  pwmd_top u_pwmd_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .enable(enable),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_duty(cfg_duty),
    .cfg_long(cfg_long), .cfg_invert(cfg_invert), .pwm_out(pwm_out)
  );

  typedef struct { logic exp; string tag; } item_t;
  item_t q[$];

  int    n_tests = 0;
  int    n_fail  = 0;
  int    obs     = 0;
  string cur_tag = "R1";
  bit    done    = 1'b0;

  // reference model state
  int          m_cnt = 0;
  logic [13:0] p_duty = '0, a_duty = '0;
  logic        p_long = 1'b0, a_long = 1'b0, p_inv = 1'b0, a_inv = 1'b0;

  function automatic logic ref_high(logic lng, logic [13:0] d, int c);
    int b, kw, w, low, k, pos, rev;
    b   = lng ? 8 : 6;
    kw  = 14 - b;
    w   = int'(d) >> kw;
    low = int'(d) & ((1 << kw) - 1);
    k   = c >> b;
    pos = c & ((1 << b) - 1);
    rev = 0;
    for (int i = 0; i < kw; i++) if (((k >> i) & 1) == 1) rev |= (1 << (kw - 1 - i));
    return pos < (w + ((rev < low) ? 1 : 0));
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pwm_out=%0b expected %0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: applies one clock of stimulus and pushes the expected output
  task automatic step(logic t, logic e, logic wv, logic [13:0] wd, logic wl, logic wi);
    item_t it;
    tick_en = t; enable = e; cfg_valid = wv;
    cfg_duty = wd; cfg_long = wl; cfg_invert = wi;
    @(posedge clk);
    if (!e) begin
      m_cnt = 0; a_duty = p_duty; a_long = p_long; a_inv = p_inv;
    end else if (t) begin
      if (m_cnt == CONV - 1) begin
        m_cnt = 0; a_duty = p_duty; a_long = p_long; a_inv = p_inv;
      end else m_cnt++;
    end
    if (wv) begin p_duty = wd; p_long = wl; p_inv = wi; end
    it.exp = e ? (ref_high(a_long, a_duty, m_cnt) ^ a_inv) : a_inv;
    it.tag = cur_tag;
    q.push_back(it);
    @(negedge clk);
    if (pwm_out !== a_inv) obs++;
    #1;
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic load(logic [13:0] d, logic l, logic inv);
    step(1'b0, 1'b0, 1'b1, d, l, inv);
    idle_n(1);
  endtask

  // one full conversion from counter zero; counts active-level ticks
  task automatic run_conv(string tag, int exp_cnt);
    obs = 0;
    step(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    for (int i = 0; i < CONV - 1; i++) step(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    check_int(tag, obs, exp_cnt);
  endtask

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check_bit(it.tag, pwm_out, it.exp);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit("R1 reset level", pwm_out, 1'b0);
    check_int("R10 ready", int'(cfg_ready), 1);
    #1 rst_n = 1'b1;

    // R2 R4 R5: long mode, width 2, seven widened cycles
    cur_tag = "R2 R4 long";
    load(14'h0087, 1'b1, 1'b0);
    run_conv("R5 long count", 14'h0087);
    idle_n(2);

    // R3 R4 R5: short mode, dense value
    cur_tag = "R3 R4 short";
    load(14'h3A5C, 1'b0, 1'b0);
    run_conv("R5 short count", 14'h3A5C);
    idle_n(2);

    // R2: widest setting fills the whole base cycle
    cur_tag = "R2 R5 max";
    load(14'h3FFF, 1'b1, 1'b0);
    run_conv("R5 max count", 14'h3FFF);
    idle_n(2);

    // R6 R8: inverted polarity, idle level high
    cur_tag = "R6 invert";
    load(14'h1234, 1'b1, 1'b1);
    check_bit("R8 idle inverted", pwm_out, 1'b1);
    run_conv("R6 invert count", 14'h1234);
    idle_n(2);

    // R7: mid-conversion write waits for the wrap
    cur_tag = "R7 shadow";
    load(14'h0087, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    for (int i = 0; i < 8000; i++) step(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 14'h2081, 1'b0, 1'b0);
    for (int i = 0; i < 8382; i++) step(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    // counter now at 16383: first base pulse of old value (width 2, at pos 1 high? pos 255 low)
    check_bit("R7 old value before wrap", pwm_out, 1'b0);
    step(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    check_bit("R7 new value after wrap", pwm_out, 1'b1);
    for (int i = 0; i < 3000; i++) step(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0);

    // R9: gapped ticks
    cur_tag = "R9 gaps";
    for (int i = 0; i < 2000; i++) step(((i % 3) == 0), 1'b1, 1'b0, '0, 1'b0, 1'b0);

    // R8: disable mid-run, then restart from zero
    cur_tag = "R8 disable";
    step(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    check_bit("R8 idle low", pwm_out, 1'b0);
    step(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0);

    // R10: back-to-back writes, last one wins
    cur_tag = "R10 last write";
    step(1'b0, 1'b0, 1'b1, 14'h0000, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1, 14'h3F00, 1'b0, 1'b0);
    idle_n(1);
    check_int("R10 ready", int'(cfg_ready), 1);
    step(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    check_bit("R10 last word active", pwm_out, 1'b1);
    for (int i = 0; i < 600; i++) step(1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0);

    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule